// File: doc/BRIEF.md
# Serial Register Access Port for Configuration Upgrade Registers

This block is the user-clock side of the serial path through which user logic reads and writes the upgrade registers. User logic supplies a clock, a serial data bit, a shift/load select and a capture/update select, and it reads one serial output bit. Inside the block are three parts:

- a 26-bit shift chain;
- a 21-bit update word that the reconfiguration logic takes as the next control value;
- the decode that picks, on each edge, which register is loaded and whether a write is allowed.

The live control word (21 bits) and status word (5 bits) belong to a slower oscillator clock domain. A two-state sender carries them into the user domain:

- In `SND_LOAD` it takes a snapshot of both words and flips a request toggle, then moves to `SND_WAIT`.
- In `SND_WAIT` it holds the snapshot stable until the receiver's acknowledge toggle, synchronised back, matches the request. It then returns to `SND_LOAD`.

The receiver synchronises the request toggle through two flops. It copies the snapshot into a user-domain mirror only when it sees the toggle change.

On each user clock edge the select inputs choose one of four operations:

| Operation | Inputs | Action |
|---|---|---|
| `OP_SHIFT` | shift/load high | Shift the chain left, taking in the serial data bit |
| `OP_CAPTURE` | shift/load low, capture/update high | Load the chain |
| `OP_UPDATE` | shift/load low, capture/update low, write allowed | Copy the chain into the update word |
| `OP_BLOCKED` | shift/load low, capture/update low, write not allowed | Change nothing |

Bit 0 of the control word is the application flag: 1 means an application configuration is running, 0 means the factory configuration. The update mode pin is 1 for remote update mode and 0 for local mode.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset the serial output is 0 and the update word is 0.
- R2: While shift/load is 1, each rising edge shifts the chain left by one bit and takes the serial input into bit 0. The serial output always shows chain bit 25, so the bits come out most significant first.
- R3: With shift/load 0 and capture/update 1 in a factory configuration (control bit 0 = 0), an edge loads the chain with the status word in bits 25:21 and the update word in bits 20:0.
- R4: The same capture in an application configuration (control bit 0 = 1) loads the status word in bits 25:21 and the control word in bits 20:0.
- R5: With both selects 0, in remote mode (mode pin 1) and a factory configuration, an edge copies chain bits 20:0 into the update word.
- R6: In local mode (mode pin 0), an edge with both selects 0 leaves the update word unchanged.
- R7: In an application configuration, an edge with both selects 0 leaves the update word unchanged.
- R8: While shift/load is 1, the capture/update input has no effect. No capture replaces the shifted data, and the update word does not change.
- R9: New control and status values from the oscillator domain appear in later captures once the toggle handshake has completed. A value is never mixed from two transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock for the chain, the update word and the mirror |
| rst_n | input | 1 | Active-low reset, user domain |
| sdi | input | 1 | Serial data into chain bit 0 |
| shift_ld | input | 1 | 1 = shift, 0 = capture or update |
| capt_upd | input | 1 | 1 = capture, 0 = update (when shift_ld is 0) |
| remote_mode | input | 1 | 1 = remote update mode, 0 = local mode |
| sdo | output | 1 | Serial data out, chain bit 25 |
| upd_word | output | 21 | Update word, taken as the next control value |
| osc_clk | input | 1 | Oscillator-domain clock |
| osc_rst_n | input | 1 | Active-low reset, oscillator domain |
| ctrl_live | input | 21 | Live control word; bit 0 is the application flag |
| stat_live | input | 5 | Live status word |

## Verification
The shift path is tried with patterns whose bits differ in every position. Reading them back one bit per edge shows whether the chain moves in the right direction and whether the status and word fields sit in the right bit positions.

Captures are taken in both the factory and the application state with distinct status, control and update values. A wrong source for bits 20:0 therefore gives a visibly different word.

Update edges are issued in all three gating cases (factory and remote, local mode, application state). Update-word values that differ before and after each edge show which gate let a write through.

Shifting with capture/update held high, and then again held low, tells a chain that ignores that input apart from one that captures or updates in the middle of a shift.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
    localparam int STAT_W = 5;
    localparam int CTRL_W = 21;

    typedef enum logic [1:0] {
        OP_SHIFT,
        OP_CAPTURE,
        OP_UPDATE,
        OP_BLOCKED
    } port_op_t;

    typedef enum logic {
        SND_LOAD,
        SND_WAIT
    } snd_state_t;
endpackage

// File: rtl/cfg_snap_sender.sv
module cfg_snap_sender
    import cfg_port_pkg::*;
#(
    parameter int W = STAT_W + CTRL_W
) (
    input  logic         osc_clk,
    input  logic         osc_rst_n,
    input  logic [W-1:0] live,
    input  logic         ack_tgl,
    output logic [W-1:0] snap,
    output logic         req_tgl
);
    snd_state_t state, state_nx;
    logic ack_s1, ack_s2;

    always_ff @(posedge osc_clk or negedge osc_rst_n) begin
        if (!osc_rst_n) begin
            ack_s1 <= 1'b0;
            ack_s2 <= 1'b0;
        end else begin
            ack_s1 <= ack_tgl;
            ack_s2 <= ack_s1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SND_LOAD: state_nx = SND_WAIT;
            SND_WAIT: if (ack_s2 == req_tgl) state_nx = SND_LOAD;
        endcase
    end

    always_ff @(posedge osc_clk or negedge osc_rst_n) begin
        if (!osc_rst_n) state <= SND_LOAD;
        else            state <= state_nx;
    end

    always_ff @(posedge osc_clk or negedge osc_rst_n) begin
        if (!osc_rst_n) begin
            snap    <= '0;
            req_tgl <= 1'b0;
        end else begin
            unique case (state)
                SND_LOAD: begin
                    snap    <= live;
                    req_tgl <= ~req_tgl;
                end
                SND_WAIT: begin
                end
            endcase
        end
    end

    // R9: snapshot stays still while the receiver has not acknowledged
    a_r9_snap_held: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
        (state == SND_WAIT && ack_s2 != req_tgl) |=> $stable(snap));

    // R9: a request toggle only moves when leaving SND_LOAD
    a_r9_req_from_load: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
        (state == SND_WAIT) |=> $stable(req_tgl));
endmodule

// File: rtl/cfg_snap_receiver.sv
module cfg_snap_receiver
    import cfg_port_pkg::*;
#(
    parameter int W = STAT_W + CTRL_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] snap,
    input  logic         req_tgl,
    output logic [W-1:0] mirror,
    output logic         ack_tgl
);
    logic req_s1, req_s2, req_s3;
    logic new_data;

    assign new_data = req_s2 ^ req_s3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_s1  <= 1'b0;
            req_s2  <= 1'b0;
            req_s3  <= 1'b0;
            mirror  <= '0;
            ack_tgl <= 1'b0;
        end else begin
            req_s1 <= req_tgl;
            req_s2 <= req_s1;
            req_s3 <= req_s2;
            if (new_data) begin
                mirror  <= snap;
                ack_tgl <= req_s2;
            end
        end
    end

    // R9: the mirror changes only when a fresh toggle has been seen
    a_r9_mirror_on_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        !new_data |=> $stable(mirror));
endmodule

// File: rtl/cfg_shift_chain.sv
module cfg_shift_chain
    import cfg_port_pkg::*;
#(
    parameter int SW = STAT_W,
    parameter int CW = CTRL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sdi,
    input  logic          shift_ld,
    input  logic          capt_upd,
    input  logic          remote_mode,
    input  logic [SW-1:0] stat_m,
    input  logic [CW-1:0] ctrl_m,
    output logic          sdo,
    output logic [CW-1:0] upd_word
);
    localparam int CHW = SW + CW;

    logic [CHW-1:0] chain;
    logic           app_cfg;
    port_op_t       op;

    assign app_cfg = ctrl_m[0];
    assign sdo     = chain[CHW-1];

    always_comb begin
        if (shift_ld)                     op = OP_SHIFT;
        else if (capt_upd)                op = OP_CAPTURE;
        else if (remote_mode && !app_cfg) op = OP_UPDATE;
        else                              op = OP_BLOCKED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain    <= '0;
            upd_word <= '0;
        end else begin
            unique case (op)
                OP_SHIFT:   chain <= {chain[CHW-2:0], sdi};
                OP_CAPTURE: chain <= app_cfg ? {stat_m, ctrl_m} : {stat_m, upd_word};
                OP_UPDATE:  upd_word <= chain[CW-1:0];
                OP_BLOCKED: begin
                end
            endcase
        end
    end

    // R2: output after a shift edge is the bit that sat just below the top
    a_r2_shift_order: assert property (@(posedge clk) disable iff (!rst_n)
        shift_ld |=> (sdo == $past(chain[CHW-2])));

    // R8: shifting never touches the update word, whatever capt_upd is
    a_r8_shift_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        shift_ld |=> $stable(upd_word));

    // R6 and R7: a write outside factory-and-remote leaves the update word
    a_r6_r7_gated_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_ld && !capt_upd && (!remote_mode || ctrl_m[0])) |=> $stable(upd_word));

    // R3: a capture edge does not alter the update word
    a_r3_capture_keeps_word: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_ld && capt_upd) |=> $stable(upd_word));
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
    import cfg_port_pkg::*;
#(
    parameter int SW = STAT_W,
    parameter int CW = CTRL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sdi,
    input  logic          shift_ld,
    input  logic          capt_upd,
    input  logic          remote_mode,
    output logic          sdo,
    output logic [CW-1:0] upd_word,
    input  logic          osc_clk,
    input  logic          osc_rst_n,
    input  logic [CW-1:0] ctrl_live,
    input  logic [SW-1:0] stat_live
);
    localparam int TW = SW + CW;

    logic [TW-1:0] snap, mirror;
    logic          req_tgl, ack_tgl;

    cfg_snap_sender #(.W(TW)) u_sender (
        .osc_clk   (osc_clk),
        .osc_rst_n (osc_rst_n),
        .live      ({stat_live, ctrl_live}),
        .ack_tgl   (ack_tgl),
        .snap      (snap),
        .req_tgl   (req_tgl)
    );

    cfg_snap_receiver #(.W(TW)) u_receiver (
        .clk     (clk),
        .rst_n   (rst_n),
        .snap    (snap),
        .req_tgl (req_tgl),
        .mirror  (mirror),
        .ack_tgl (ack_tgl)
    );

    cfg_shift_chain #(.SW(SW), .CW(CW)) u_chain (
        .clk         (clk),
        .rst_n       (rst_n),
        .sdi         (sdi),
        .shift_ld    (shift_ld),
        .capt_upd    (capt_upd),
        .remote_mode (remote_mode),
        .stat_m      (mirror[TW-1:CW]),
        .ctrl_m      (mirror[CW-1:0]),
        .sdo         (sdo),
        .upd_word    (upd_word)
    );
endmodule

// File: tb/tb_cfg_serial_port.sv
module tb_cfg_serial_port;
    logic        clk = 1'b0, osc_clk = 1'b0;
    logic        rst_n = 1'b0, osc_rst_n = 1'b0;
    logic        sdi = 1'b0, shift_ld = 1'b0, capt_upd = 1'b1, remote_mode = 1'b1;
    logic        sdo;
    logic [20:0] upd_word, ctrl_live = '0;
    logic [4:0]  stat_live = '0;
    int errors = 0, checks = 0;
    bit done = 0;

    always #5  clk = ~clk;
    always #40 osc_clk = ~osc_clk;

    cfg_serial_port dut (
        .clk(clk), .rst_n(rst_n), .sdi(sdi), .shift_ld(shift_ld),
        .capt_upd(capt_upd), .remote_mode(remote_mode), .sdo(sdo),
        .upd_word(upd_word), .osc_clk(osc_clk), .osc_rst_n(osc_rst_n),
        .ctrl_live(ctrl_live), .stat_live(stat_live)
    );

    task automatic check(input string req, input logic [25:0] act, input logic [25:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic shift_word(input logic [25:0] din, input logic cu, output logic [25:0] dout);
        for (int i = 25; i >= 0; i--) begin
            dout[i]  = sdo;
            sdi      = din[i];
            shift_ld = 1'b1;
            capt_upd = cu;
            @(posedge clk); @(negedge clk);
        end
        shift_ld = 1'b0;
        capt_upd = 1'b1;
    endtask

    task automatic capture_read(output logic [25:0] dout);
        shift_ld = 1'b0; capt_upd = 1'b1;
        @(posedge clk); @(negedge clk);
        shift_word(26'h0, 1'b1, dout);
    endtask

    task automatic update_edge();
        shift_ld = 1'b0; capt_upd = 1'b0;
        @(posedge clk); @(negedge clk);
        capt_upd = 1'b1;
    endtask

    task automatic settle();
        repeat (150) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 sdo", {25'b0, sdo}, 26'h0);
        check("R1 upd_word", {5'b0, upd_word}, 26'h0);
    endtask

    task automatic t_factory_write();
        logic [25:0] d;
        stat_live = 5'b10110; ctrl_live = 21'h0; remote_mode = 1'b1;
        settle();
        capture_read(d);
        check("R3 capture factory initial", d, {5'b10110, 21'h0});
        shift_word({5'b0, 21'h1A5A5A}, 1'b0, d);
        update_edge();
        check("R5 update word", {5'b0, upd_word}, {5'b0, 21'h1A5A5A});
        capture_read(d);
        check("R3 capture factory word", d, {5'b10110, 21'h1A5A5A});
    endtask

    task automatic t_shift_ignores_cu();
        logic [25:0] d, d2;
        shift_word(26'h2C3_9E17, 1'b1, d);
        check("R8 no write while shifting cu=1", {5'b0, upd_word}, {5'b0, 21'h1A5A5A});
        shift_word(26'h155_AA33, 1'b0, d2);
        check("R2 R8 shifted data intact", d2, 26'h2C3_9E17);
        check("R8 no write while shifting cu=0", {5'b0, upd_word}, {5'b0, 21'h1A5A5A});
        shift_word(26'h0, 1'b1, d);
        check("R2 second pattern", d, 26'h155_AA33);
    endtask

    task automatic t_local_blocked();
        logic [25:0] d;
        remote_mode = 1'b0;
        shift_word({5'b0, 21'h0F00F2}, 1'b0, d);
        update_edge();
        check("R6 local mode write ignored", {5'b0, upd_word}, {5'b0, 21'h1A5A5A});
        remote_mode = 1'b1;
    endtask

    task automatic t_application();
        logic [25:0] d;
        stat_live = 5'b01001; ctrl_live = 21'h0F0F1;
        settle();
        capture_read(d);
        check("R4 capture application", d, {5'b01001, 21'h0F0F1});
        shift_word({5'b0, 21'h055554}, 1'b0, d);
        update_edge();
        check("R7 application write ignored", {5'b0, upd_word}, {5'b0, 21'h1A5A5A});
        stat_live = 5'b11111; ctrl_live = 21'h1FFF03;
        settle();
        capture_read(d);
        check("R9 new values reach capture", d, {5'b11111, 21'h1FFF03});
    endtask

    task automatic t_back_to_factory();
        logic [25:0] d;
        stat_live = 5'b00011; ctrl_live = 21'h000010;
        settle();
        shift_word({5'b0, 21'h0ABCDE}, 1'b0, d);
        update_edge();
        check("R5 write after return to factory", {5'b0, upd_word}, {5'b0, 21'h0ABCDE});
        capture_read(d);
        check("R3 R9 capture after return", d, {5'b00011, 21'h0ABCDE});
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1; osc_rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_factory_write();
        t_shift_ignores_cu();
        t_local_blocked();
        t_application();
        t_back_to_factory();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule